// File: doc/BRIEF.md
# Serial Unlock Key Detector

This block sits on the target side of a serial programming link. It watches three asynchronous pins: a target reset line, a serial clock and a serial data line. From these it decides whether the device may switch into program/verify mode. The reset line has to go high and then low to arm a capture. After that, 32 bits are shifted in on rising serial clock edges and compared with a fixed unlock word. The mode is entered only when that word matches and the reset line then rises within a bounded number of system clock cycles.

While the mode is active, the block raises a mode flag and a request to float every unused I/O pin. After entry it waits a settling interval and ignores serial clock edges until that interval is over. From then on, each qualified rising serial clock edge gives a one-cycle pulse, together with the data bit sampled on that edge, for a downstream command decoder. Dropping the reset line leaves the mode at once. All three pins pass through synchronizers into the system clock domain.

Top module: `key_unlock_detect`

## Requirements
- R1: After system reset, `modeActive`, `ioHiz` and `clkQual` are low.
- R2: A capture is armed only after the synchronized reset line has been seen high and then low. Key bits sent without that pulse never lead to mode entry.
- R3: The captured word must equal 0x4D434851 (KEY_VALUE). Any other 32-bit word returns the block to idle without entry.
- R4: The first captured bit is bit 31 of the key. After a matching key, a rise of the reset line within MAX_GAP cycles sets `modeActive`.
- R5: If the reset line rises after the MAX_GAP window has run out, the mode is not entered.
- R6: If the reset line rises before all 32 bits have been captured, the capture is discarded and the mode is not entered.
- R7: Serial clock edges in the first SETTLE_CYCLES cycles after entry produce no `clkQual` pulse.
- R8: After the settling interval, each rising serial clock edge produces exactly one `clkQual` pulse, with `datQual` equal to the data bit at that edge.
- R9: A fall of the reset line while in the mode clears `modeActive`. Later serial clock edges produce no pulses.
- R10: `ioHiz` is high exactly while `modeActive` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low system reset, asynchronous |
| tgtRstLine | input | 1 | Asynchronous target reset line |
| serClkIn | input | 1 | Asynchronous serial clock |
| serDatIn | input | 1 | Asynchronous serial data |
| modeActive | output | 1 | Program/verify mode is active |
| ioHiz | output | 1 | Request to place unused I/O in high impedance |
| clkQual | output | 1 | One-cycle pulse for each qualified serial clock rise |
| datQual | output | 1 | Synchronized data bit that goes with `clkQual` |

## Verification
A wrong internal state shows up at the ports as a mode flag that rises when it should not, or fails to rise. A stray bit count, a wrong shift order or a comparison error appears as a missing or unexpected entry within a few cycles of the reset line rising. A settle counter that is out of step shows up as a `clkQual` pulse during the quiet interval, or as a lost first bit. The scoreboard catches both on the very edge concerned, because every pulse must match a queued bit and no pulse may arrive while the queue is empty.

// File: rtl/unlock_pkg.sv
package unlock_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMHI,
    ST_SHIFT,
    ST_GAP,
    ST_SETTLE,
    ST_ACTIVE
  } unlockState_e;

  typedef struct packed {
    logic clrBits;
    logic shiftEn;
    logic clrGap;
    logic incGap;
    logic clrSettle;
    logic incSettle;
  } ctrlStrobe_t;

  typedef struct packed {
    logic lineHigh;
    logic lineRise;
    logic lineFall;
    logic serRise;
    logic keyDone;
    logic keyMatch;
    logic gapExpired;
    logic settleDone;
  } dpStatus_t;

endpackage

// File: rtl/unlock_dp.sv
module unlock_dp
  import unlock_pkg::*;
#(
  parameter int KEY_WIDTH = 32,
  parameter logic [KEY_WIDTH-1:0] KEY_VALUE = 32'h4D434851,
  parameter int MAX_GAP = 64,
  parameter int SETTLE_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tgtRstLine,
  input  logic        serClkIn,
  input  logic        serDatIn,
  input  ctrlStrobe_t strobe,
  output dpStatus_t   status,
  output logic        datBit
);

  localparam int BIT_W = $clog2(KEY_WIDTH + 1);
  localparam int GAP_W = $clog2(MAX_GAP + 1);
  localparam int SET_W = $clog2(SETTLE_CYCLES + 1);
  localparam int PIN_N = 3;

  logic [SYNC_STAGES-1:0][PIN_N-1:0] syncQ;
  logic [PIN_N-1:0] pinSync;
  logic lineLast, serLast;
  logic [KEY_WIDTH-1:0] shiftReg;
  logic [BIT_W-1:0] bitCnt;
  logic [GAP_W-1:0] gapCnt;
  logic [SET_W-1:0] settleCnt;

  // two or more flops per pin; index 0 = data, 1 = serial clock, 2 = reset line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], {tgtRstLine, serClkIn, serDatIn}};
  end

  assign pinSync = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineLast <= 1'b0;
      serLast  <= 1'b0;
    end else begin
      lineLast <= pinSync[2];
      serLast  <= pinSync[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (strobe.clrBits) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (strobe.shiftEn) begin
      shiftReg <= {shiftReg[KEY_WIDTH-2:0], pinSync[0]};
      bitCnt   <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              gapCnt <= '0;
    else if (strobe.clrGap) gapCnt <= '0;
    else if (strobe.incGap) gapCnt <= gapCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 settleCnt <= '0;
    else if (strobe.clrSettle) settleCnt <= '0;
    else if (strobe.incSettle) settleCnt <= settleCnt + 1'b1;
  end

  always_comb begin
    status.lineHigh   = pinSync[2];
    status.lineRise   = pinSync[2] & ~lineLast;
    status.lineFall   = ~pinSync[2] & lineLast;
    status.serRise    = pinSync[1] & ~serLast;
    status.keyDone    = (bitCnt == BIT_W'(KEY_WIDTH));
    status.keyMatch   = (shiftReg == KEY_VALUE);
    status.gapExpired = (gapCnt >= GAP_W'(MAX_GAP));
    status.settleDone = (settleCnt == SET_W'(SETTLE_CYCLES));
  end

  assign datBit = pinSync[0];

  // R6: never more bits than the key width
  p_bits_bounded_r6: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= BIT_W'(KEY_WIDTH));

  // R5: the window counter never runs beyond its limit
  p_gap_bounded_r5: assert property (@(posedge clk) disable iff (!rstN)
    gapCnt <= GAP_W'(MAX_GAP));

endmodule

// File: rtl/unlock_ctrl.sv
module unlock_ctrl
  import unlock_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        modeActive,
  output logic        ioHiz,
  output logic        clkQual
);

  unlockState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE:  if (status.lineHigh) nextState = ST_ARMHI;
      ST_ARMHI: if (status.lineFall) begin
        nextState      = ST_SHIFT;
        strobe.clrBits = 1'b1;
      end
      ST_SHIFT: begin
        if (status.lineRise) begin
          nextState = ST_IDLE;
        end else if (status.keyDone) begin
          if (status.keyMatch) begin
            nextState     = ST_GAP;
            strobe.clrGap = 1'b1;
          end else begin
            nextState = ST_IDLE;
          end
        end else if (status.serRise) begin
          strobe.shiftEn = 1'b1;
        end
      end
      ST_GAP: begin
        if (status.lineRise && !status.gapExpired) begin
          nextState        = ST_SETTLE;
          strobe.clrSettle = 1'b1;
        end else if (status.gapExpired) begin
          nextState = ST_IDLE;
        end else begin
          strobe.incGap = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (status.lineFall)        nextState = ST_IDLE;
        else if (status.settleDone) nextState = ST_ACTIVE;
        else                        strobe.incSettle = 1'b1;
      end
      ST_ACTIVE: if (status.lineFall) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign modeActive = (state == ST_SETTLE) || (state == ST_ACTIVE);
  assign ioHiz      = modeActive;
  assign clkQual    = (state == ST_ACTIVE) && status.serRise;

  // R7: a qualified pulse only once the settle counter has finished
  p_qual_after_settle_r7: assert property (@(posedge clk) disable iff (!rstN)
    clkQual |-> (modeActive && status.settleDone));

  // R9: a line fall in the mode leaves it on the next cycle
  p_exit_on_fall_r9: assert property (@(posedge clk) disable iff (!rstN)
    (modeActive && status.lineFall) |=> !modeActive);

  // R3: a full capture that does not match goes back to idle
  p_mismatch_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SHIFT && !status.lineRise && status.keyDone && !status.keyMatch)
      |=> (state == ST_IDLE));

  // R4: the mode is only entered from the post-key window
  p_entry_from_gap_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeActive) |-> ($past(state) == ST_GAP));

endmodule

// File: rtl/key_unlock_detect.sv
module key_unlock_detect
  import unlock_pkg::*;
#(
  parameter int KEY_WIDTH = 32,
  parameter logic [KEY_WIDTH-1:0] KEY_VALUE = 32'h4D434851,
  parameter int MAX_GAP = 64,
  parameter int SETTLE_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic tgtRstLine,
  input  logic serClkIn,
  input  logic serDatIn,
  output logic modeActive,
  output logic ioHiz,
  output logic clkQual,
  output logic datQual
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  unlock_dp #(
    .KEY_WIDTH(KEY_WIDTH),
    .KEY_VALUE(KEY_VALUE),
    .MAX_GAP(MAX_GAP),
    .SETTLE_CYCLES(SETTLE_CYCLES),
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk(clk),
    .rstN(rstN),
    .tgtRstLine(tgtRstLine),
    .serClkIn(serClkIn),
    .serDatIn(serDatIn),
    .strobe(strobe),
    .status(status),
    .datBit(datQual)
  );

  unlock_ctrl ctrl_i (
    .clk(clk),
    .rstN(rstN),
    .status(status),
    .strobe(strobe),
    .modeActive(modeActive),
    .ioHiz(ioHiz),
    .clkQual(clkQual)
  );

endmodule

// File: tb/key_unlock_detect_tb_top.sv
module key_unlock_detect_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_GAP = 64;
  localparam int SETTLE = 16;
  localparam logic [31:0] GOOD_KEY = 32'h4D434851;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tgtRstLine = 1'b0;
  logic serClkIn = 1'b0;
  logic serDatIn = 1'b0;
  logic modeActive, ioHiz, clkQual, datQual;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  key_unlock_detect #(.MAX_GAP(MAX_GAP), .SETTLE_CYCLES(SETTLE)) dut_i (
    .clk(clk), .rstN(rstN), .tgtRstLine(tgtRstLine), .serClkIn(serClkIn),
    .serDatIn(serDatIn), .modeActive(modeActive), .ioHiz(ioHiz),
    .clkQual(clkQual), .datQual(datQual)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sendBit(input bit b, input bit push);
    serDatIn = b;
    if (push) expQ.push_back(b);
    waitCyc(3);
    serClkIn = 1'b1;
    waitCyc(4);
    serClkIn = 1'b0;
    waitCyc(4);
  endtask

  task automatic sendTop(input logic [31:0] word, input int n);
    for (int i = 31; i > 31 - n; i--) sendBit(word[i], 1'b0);
  endtask

  task automatic checkMode(input bit exp, input string tag);
    chk(modeActive == exp, tag, int'(modeActive), int'(exp));
    chk(ioHiz == exp, {tag, " R10"}, int'(ioHiz), int'(exp));
  endtask

  // monitor: every qualified pulse must match the next queued bit
  always @(negedge clk) begin
    if (rstN && clkQual) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R7/R9 unexpected clkQual", 1, 0);
      end else begin
        bit e;
        e = expQ.pop_front();
        chk(datQual == e, "R8 datQual", int'(datQual), int'(e));
      end
    end
  end

  initial begin
    waitCyc(3);
    chk(!modeActive && !ioHiz && !clkQual, "R1 reset state",
        int'({modeActive, ioHiz, clkQual}), 0);
    rstN = 1'b1;
    waitCyc(3);
    chk(!modeActive && !ioHiz && !clkQual, "R1 after release",
        int'({modeActive, ioHiz, clkQual}), 0);

    // R2: key with no arming pulse
    sendTop(GOOD_KEY, 32);
    tgtRstLine = 1'b1;
    waitCyc(10);
    checkMode(1'b0, "R2 no arming pulse");

    // R3: wrong key (low bit flipped)
    tgtRstLine = 1'b0;
    waitCyc(5);
    sendTop(GOOD_KEY ^ 32'h1, 32);
    waitCyc(3);
    tgtRstLine = 1'b1;
    waitCyc(10);
    checkMode(1'b0, "R3 wrong key lsb");

    // R4 order: bit-reversed sequence must also fail
    tgtRstLine = 1'b0;
    waitCyc(5);
    sendTop({<<{GOOD_KEY}}, 32);
    waitCyc(3);
    tgtRstLine = 1'b1;
    waitCyc(10);
    checkMode(1'b0, "R4 lsb-first order rejected");

    // R6: early rise
    tgtRstLine = 1'b0;
    waitCyc(5);
    sendTop(GOOD_KEY, 20);
    tgtRstLine = 1'b1;
    waitCyc(10);
    checkMode(1'b0, "R6 early rise");
    tgtRstLine = 1'b0;
    waitCyc(5);
    sendTop(GOOD_KEY << 20, 12);
    tgtRstLine = 1'b1;
    waitCyc(10);
    checkMode(1'b0, "R6 leftover bits");

    // R5: late rise
    tgtRstLine = 1'b0;
    waitCyc(5);
    sendTop(GOOD_KEY, 32);
    waitCyc(MAX_GAP + 20);
    tgtRstLine = 1'b1;
    waitCyc(10);
    checkMode(1'b0, "R5 late rise");

    // R4: valid entry
    tgtRstLine = 1'b0;
    waitCyc(5);
    sendTop(GOOD_KEY, 32);
    waitCyc(3);
    tgtRstLine = 1'b1;
    waitCyc(5);
    checkMode(1'b1, "R4 entry");
    // R7: an edge within the settle interval
    serClkIn = 1'b1;
    waitCyc(3);
    serClkIn = 1'b0;
    waitCyc(30);
    checkMode(1'b1, "R4 held");
    // R8: qualified bits
    for (int i = 0; i < 8; i++) sendBit(bit'((8'hA7 >> i) & 1), 1'b1);
    chk(expQ.size() == 0, "R8 all bits seen", expQ.size(), 0);

    // R9: exit
    tgtRstLine = 1'b0;
    waitCyc(5);
    checkMode(1'b0, "R9 exit");
    sendBit(1'b1, 1'b0);
    sendBit(1'b0, 1'b0);
    checkMode(1'b0, "R9 stays out");

    // re-entry after a fresh pulse
    tgtRstLine = 1'b1;
    waitCyc(5);
    tgtRstLine = 1'b0;
    waitCyc(5);
    sendTop(GOOD_KEY, 32);
    tgtRstLine = 1'b1;
    waitCyc(SETTLE + 15);
    checkMode(1'b1, "R4 re-entry");
    sendBit(1'b0, 1'b1);
    sendBit(1'b1, 1'b1);
    sendBit(1'b1, 1'b1);
    sendBit(1'b0, 1'b1);
    chk(expQ.size() == 0, "R8 re-entry bits", expQ.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule